// File: doc/BRIEF.md
# Offload Stream Command Processor

This block sits between a command channel and the per-connection state of an offload engine. Commands arrive one byte per beat over a valid/ready input with an end-of-message marker on the final byte. The first byte says what to do, and the next four bytes carry a big-endian stream identifier.

A setup command carries a full connection, record and crypto context. The block keeps the fields the data path needs in a small table, in the entry picked by the low bits of the stream identifier. It then sends an eight-byte acknowledgement on a valid/ready output. A teardown command marks the entry invalid and sends nothing back.

A message with an unknown command byte or the wrong length is read up to its marker and then dropped, with a one-cycle error pulse. The data path reads the table through a combinational lookup port.

Top module: `offload_cmd_proc`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, err_pulse is 0 and every table entry reads as invalid.
- R2: Byte 0 of a message is the command (0x01 setup, 0x02 teardown). Bytes 1 to 4 are the stream id, most significant byte first. The byte accepted with in_last=1 ends the message.
- R3: A setup of exactly 153 bytes writes entry sid[IDX_W-1:0] and marks it valid. The entry holds the stream id, flags from the low nibble of byte 24 (bit 3 TCP, bit 2 initialized, bit 1 valid, bit 0 IPv6), the source port from bytes 25-26, the destination port from bytes 27-28, the TCP sequence from bytes 33-36, the record type/version byte from byte 64 (upper nibble 3 means TLS 1.2) and the 256-bit key from bytes 121-152, with byte 121 most significant. Multi-byte fields are big-endian.
- R4: Each accepted setup produces exactly 8 output bytes: 00 00 00 81, then the stream id, most significant byte first. out_last is 1 only on the eighth byte. The first byte is valid in the second cycle after the cycle in which the last input byte is accepted.
- R5: A teardown of exactly 5 bytes clears the valid bit of entry sid[IDX_W-1:0], leaves the other entries unchanged and produces no output and no error.
- R6: A message whose command byte is neither 0x01 nor 0x02 is consumed up to in_last and then dropped. err_pulse is 1 for exactly the one cycle after the last byte is accepted. The table and the output are not touched.
- R7: A setup that is not exactly 153 bytes long, or a teardown that is not exactly 5 bytes long, raises the same error pulse. It changes no table entry and produces no response.
- R8: in_ready is 0 in the cycle after a last byte is accepted, and for as long as out_valid is 1.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last stay unchanged.
- R10: A setup whose stream id shares the low IDX_W bits with a valid entry overwrites that entry with the new context.
- R11: The lookup outputs show the entry selected by lkp_idx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Command byte accepted when high with in_valid |
| in_data | input | 8 | Command byte |
| in_last | input | 1 | Marks the final byte of a message |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Consumer takes the response byte |
| out_data | output | 8 | Response byte |
| out_last | output | 1 | Final response byte |
| err_pulse | output | 1 | One-cycle pulse for a dropped message |
| lkp_idx | input | IDX_W | Table entry to read |
| lkp_valid | output | 1 | Entry holds a live stream |
| lkp_sid | output | 32 | Stored stream id |
| lkp_flags | output | 4 | Stored connection flags |
| lkp_sport | output | 16 | Stored source port |
| lkp_dport | output | 16 | Stored destination port |
| lkp_seq | output | 32 | Stored TCP sequence number |
| lkp_rver | output | 8 | Stored record type/version byte |
| lkp_key | output | 256 | Stored cipher key |

## Verification
The bench builds the block with TBL_DEPTH=8, so IDX_W is 3 and every one of the eight entries can be checked for its reset state. With three index bits, the ids 0x12345673 and 0x0000000B both land in entry 3, which reaches the overwrite case with small ids. The counter width stays at its default of 8, so a 153-byte setup and a 100-byte short setup both sit well inside the counter range used for the length checks.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

   // command and event codes
   localparam logic [7:0]  CMD_SETUP = 8'h01;
   localparam logic [7:0]  CMD_TEAR  = 8'h02;
   localparam logic [31:0] RESP_OPC  = 32'h0000_0081;

   // byte offsets inside a message (the parser decodes these positions)
   localparam int OFF_SID   = 1;
   localparam int OFF_FLAGS = 24;
   localparam int OFF_SPORT = 25;
   localparam int OFF_DPORT = 27;
   localparam int OFF_SEQ   = 33;
   localparam int OFF_RVER  = 64;
   localparam int OFF_KEY   = 121;

   localparam int KEY_BYTES  = 32;
   localparam int KEY_W      = KEY_BYTES * 8;
   localparam int SETUP_LEN  = 153;
   localparam int TEAR_LEN   = 5;
   localparam int RESP_BYTES = 8;

   typedef struct packed {
      logic [31:0]      sid;
      logic [3:0]       flags;
      logic [15:0]      sport;
      logic [15:0]      dport;
      logic [31:0]      seq;
      logic [7:0]       rver;
      logic [KEY_W-1:0] key;
   } ctx_t;

endpackage

// File: rtl/ocp_parser.sv
module ocp_parser
   import ocp_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_last,
   input  logic       hold,
   output logic       in_ready,
   output ctx_t       ctx,
   output logic       op_setup,
   output logic       op_tear,
   output logic       op_err
);

   generate
      if ((1 << CNT_W) - 1 <= SETUP_LEN) begin : g_cnt_chk
         $error("CNT_W too small for the setup message length");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             pend;
   logic [7:0]       opc;
   ctx_t             cap;
   logic             beat;

   function automatic logic in_win(input logic [CNT_W-1:0] c, input int off, input int n);
      return (int'(c) >= off) && (int'(c) < off + n);
   endfunction

   assign in_ready = !pend && !hold;
   assign beat     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
         opc  <= '0;
         cap  <= '0;
      end else if (pend) begin
         pend <= 1'b0;
         cnt  <= '0;
      end else if (beat) begin
         if (cnt == '0)                 opc       <= in_data;
         if (in_win(cnt, OFF_SID, 4))   cap.sid   <= {cap.sid[23:0], in_data};
         if (int'(cnt) == OFF_FLAGS)    cap.flags <= in_data[3:0];
         if (in_win(cnt, OFF_SPORT, 2)) cap.sport <= {cap.sport[7:0], in_data};
         if (in_win(cnt, OFF_DPORT, 2)) cap.dport <= {cap.dport[7:0], in_data};
         if (in_win(cnt, OFF_SEQ, 4))   cap.seq   <= {cap.seq[23:0], in_data};
         if (int'(cnt) == OFF_RVER)     cap.rver  <= in_data;
         if (in_win(cnt, OFF_KEY, KEY_BYTES))
            cap.key <= {cap.key[KEY_W-9:0], in_data};
         if (cnt != '1) cnt <= cnt + 1'b1;
         if (in_last)   pend <= 1'b1;
      end
   end

   // decision cycle: cnt now holds the message length
   assign op_setup = pend && (opc == CMD_SETUP) && (int'(cnt) == SETUP_LEN);
   assign op_tear  = pend && (opc == CMD_TEAR)  && (int'(cnt) == TEAR_LEN);
   assign op_err   = pend && !op_setup && !op_tear;
   assign ctx      = cap;

   // R2: every outcome follows the accepted end-of-message byte
   p_outcome_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_setup || op_tear || op_err) |-> $past(in_valid && in_ready && in_last));

   // R8: no byte is taken in the cycle after a message ends
   p_gap_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);

endmodule

// File: rtl/ocp_ctx_table.sv
module ocp_ctx_table
   import ocp_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_set,
   input  logic             wr_clr,
   input  logic [IDX_W-1:0] wr_idx,
   input  ctx_t             wr_ctx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output ctx_t             rd_ctx
);

   logic [DEPTH-1:0] valid_vec;
   ctx_t             ctx_arr [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic v_q;
         ctx_t c_q;
         logic hit;
         assign hit = (wr_idx == IDX_W'(e));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               c_q <= '0;
            end else if (hit && wr_set) begin
               v_q <= 1'b1;
               c_q <= wr_ctx;
            end else if (hit && wr_clr) begin
               v_q <= 1'b0;
            end
         end

         assign valid_vec[e] = v_q;
         assign ctx_arr[e]   = c_q;
      end
   endgenerate

   assign rd_valid = valid_vec[rd_idx];
   assign rd_ctx   = ctx_arr[rd_idx];

   // R3: a setup leaves its entry valid
   p_set_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> valid_vec[$past(wr_idx)]);

   // R5: a teardown leaves its entry invalid
   p_clr_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> !valid_vec[$past(wr_idx)]);

   // R5: entries other than the addressed one keep their valid bit
   p_clr_only_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ($countones(valid_vec ^ $past(valid_vec)) <= 1));

endmodule

// File: rtl/ocp_resp_tx.sv
module ocp_resp_tx
   import ocp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] load_sid,
   input  logic        out_ready,
   output logic        out_valid,
   output logic [7:0]  out_data,
   output logic        out_last
);

   localparam int SEL_W = $clog2(RESP_BYTES);

   logic [RESP_BYTES*8-1:0] sh;
   logic [SEL_W-1:0]        pos;
   logic                    busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         pos  <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sh   <= {RESP_OPC, load_sid};
         pos  <= '0;
         busy <= 1'b1;
      end else if (busy && out_ready) begin
         sh  <= {sh[RESP_BYTES*8-9:0], 8'h00};
         pos <= pos + 1'b1;
         if (pos == SEL_W'(RESP_BYTES - 1)) busy <= 1'b0;
      end
   end

   assign out_valid = busy;
   assign out_data  = sh[RESP_BYTES*8-1 -: 8];
   assign out_last  = busy && (pos == SEL_W'(RESP_BYTES - 1));

   // R9: the output holds while the consumer stalls
   p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   // R4: a response opens with the top opcode byte
   p_first_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_data == 8'h00) && !out_last);

   // R4: a new response never starts over one in flight
   p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !out_valid);

endmodule

// File: rtl/offload_cmd_proc.sv
module offload_cmd_proc
   import ocp_pkg::*;
#(
   parameter int TBL_DEPTH = 16,
   parameter int CNT_W     = 8,
   localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic              err_pulse,
   input  logic [IDX_W-1:0]  lkp_idx,
   output logic              lkp_valid,
   output logic [31:0]       lkp_sid,
   output logic [3:0]        lkp_flags,
   output logic [15:0]       lkp_sport,
   output logic [15:0]       lkp_dport,
   output logic [31:0]       lkp_seq,
   output logic [7:0]        lkp_rver,
   output logic [KEY_W-1:0]  lkp_key
);

   generate
      if (TBL_DEPTH < 2 || (TBL_DEPTH & (TBL_DEPTH - 1)) != 0 || IDX_W > 32) begin : g_depth_chk
         $error("TBL_DEPTH must be a power of two, at least 2");
      end
   endgenerate

   ctx_t cap_ctx;
   ctx_t rd_ctx;
   logic op_setup, op_tear, op_err;

   ocp_parser #(.CNT_W(CNT_W)) u_parser (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_last  (in_last),
      .hold     (out_valid),
      .in_ready (in_ready),
      .ctx      (cap_ctx),
      .op_setup (op_setup),
      .op_tear  (op_tear),
      .op_err   (op_err)
   );

   ocp_ctx_table #(.DEPTH(TBL_DEPTH)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_set   (op_setup),
      .wr_clr   (op_tear),
      .wr_idx   (cap_ctx.sid[IDX_W-1:0]),
      .wr_ctx   (cap_ctx),
      .rd_idx   (lkp_idx),
      .rd_valid (lkp_valid),
      .rd_ctx   (rd_ctx)
   );

   ocp_resp_tx u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (op_setup),
      .load_sid  (cap_ctx.sid),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   assign err_pulse = op_err;
   assign lkp_sid   = rd_ctx.sid;
   assign lkp_flags = rd_ctx.flags;
   assign lkp_sport = rd_ctx.sport;
   assign lkp_dport = rd_ctx.dport;
   assign lkp_seq   = rd_ctx.seq;
   assign lkp_rver  = rd_ctx.rver;
   assign lkp_key   = rd_ctx.key;

   // R8: input is closed while a response is pending
   p_ready_low_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R6: an error pulse lasts one cycle
   p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);

   // R6: a dropped message never starts a response
   p_err_no_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pulse && !out_valid) |=> !out_valid);

endmodule

// File: tb/offload_cmd_proc_tb.sv
module offload_cmd_proc_tb;
   import ocp_pkg::*;

   localparam int DEPTH = 8;
   localparam int IW    = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [7:0]       in_data = '0;
   logic             in_last = 1'b0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [7:0]       out_data;
   logic             out_last;
   logic             err_pulse;
   logic [IW-1:0]    lkp_idx = '0;
   logic             lkp_valid;
   logic [31:0]      lkp_sid;
   logic [3:0]       lkp_flags;
   logic [15:0]      lkp_sport;
   logic [15:0]      lkp_dport;
   logic [31:0]      lkp_seq;
   logic [7:0]       lkp_rver;
   logic [KEY_W-1:0] lkp_key;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // message fields used by mbyte()
   logic [7:0]  m_op;
   logic [31:0] m_sid;
   logic [3:0]  m_flags;
   logic [15:0] m_sport, m_dport;
   logic [31:0] m_seq;
   logic [7:0]  m_rver, m_kseed;

   always #5 clk = ~clk;

   offload_cmd_proc #(.TBL_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
      .err_pulse(err_pulse), .lkp_idx(lkp_idx), .lkp_valid(lkp_valid), .lkp_sid(lkp_sid),
      .lkp_flags(lkp_flags), .lkp_sport(lkp_sport), .lkp_dport(lkp_dport),
      .lkp_seq(lkp_seq), .lkp_rver(lkp_rver), .lkp_key(lkp_key)
   );

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [KEY_W-1:0] act, input logic [KEY_W-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mbyte(input int off);
      if (off == 0) return m_op;
      if (off >= 1 && off <= 4) return m_sid[8*(4-off) +: 8];
      if (off == OFF_FLAGS) return {4'hC, m_flags};
      if (off == OFF_SPORT) return m_sport[15:8];
      if (off == OFF_SPORT + 1) return m_sport[7:0];
      if (off == OFF_DPORT) return m_dport[15:8];
      if (off == OFF_DPORT + 1) return m_dport[7:0];
      if (off >= OFF_SEQ && off < OFF_SEQ + 4) return m_seq[8*(OFF_SEQ+3-off) +: 8];
      if (off == OFF_RVER) return m_rver;
      if (off >= OFF_KEY && off < OFF_KEY + KEY_BYTES) return m_kseed + 8'(off - OFF_KEY);
      return 8'(off) ^ 8'h5A;
   endfunction

   function automatic logic [KEY_W-1:0] exp_key(input logic [7:0] seed);
      logic [KEY_W-1:0] k = '0;
      for (int i = 0; i < KEY_BYTES; i++) k[8*(KEY_BYTES-1-i) +: 8] = seed + 8'(i);
      return k;
   endfunction

   task automatic send_byte(input logic [7:0] b, input logic last);
      @(negedge clk);
      in_valid = 1'b1; in_data = b; in_last = last;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
   endtask

   // ends at the negedge of the decision cycle
   task automatic send_msg(input int len);
      for (int i = 0; i < len; i++) send_byte(mbyte(i), i == len - 1);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic set_fields(input logic [7:0] op, input logic [31:0] sid, input logic [3:0] fl,
                             input logic [15:0] sp, input logic [15:0] dp, input logic [31:0] sq,
                             input logic [7:0] rv, input logic [7:0] ks);
      m_op = op; m_sid = sid; m_flags = fl; m_sport = sp; m_dport = dp;
      m_seq = sq; m_rver = rv; m_kseed = ks;
   endtask

   // called at the negedge where byte 0 is shown
   task automatic recv_resp(input logic [31:0] sid, input bit stall);
      logic [63:0] exp = {RESP_OPC, sid};
      logic [7:0]  held;
      for (int k = 0; k < RESP_BYTES; k++) begin
         if (stall && k == 2) begin
            out_ready = 1'b0;
            held = out_data;
            for (int s = 0; s < 3; s++) begin
               @(negedge clk);
               chk(out_valid && out_data == held && !out_last, "R9", "stalled byte",
                   {out_valid, out_data}, {1'b1, held});
            end
            out_ready = 1'b1;
         end
         chk(out_valid && out_data == exp[8*(7-k) +: 8], "R4", $sformatf("resp byte %0d", k),
             out_data, exp[8*(7-k) +: 8]);
         chk(out_last == (k == 7), "R4", "out_last", out_last, (k == 7));
         chk(!in_ready, "R8", "in_ready during response", in_ready, 0);
         @(negedge clk);
      end
      chk(!out_valid, "R4", "response ends after 8 bytes", out_valid, 0);
   endtask

   task automatic do_setup(input bit stall);
      send_msg(SETUP_LEN);
      chk(!err_pulse, "R3", "no error on setup", err_pulse, 0);
      chk(!in_ready, "R8", "in_ready after last byte", in_ready, 0);
      chk(!out_valid, "R4", "no response in decision cycle", out_valid, 0);
      @(negedge clk);
      chk(out_valid, "R4", "response valid second cycle", out_valid, 1);
      recv_resp(m_sid, stall);
   endtask

   task automatic chk_entry(input logic [31:0] sid, input logic [3:0] fl, input logic [15:0] sp,
                            input logic [15:0] dp, input logic [31:0] sq, input logic [7:0] rv,
                            input logic [7:0] ks, input string req);
      lkp_idx = sid[IW-1:0];
      #1;
      chk(lkp_valid, req, "entry valid (R11)", lkp_valid, 1);
      chk(lkp_sid == sid, req, "stored sid", lkp_sid, sid);
      chk(lkp_flags == fl && lkp_sport == sp && lkp_dport == dp, req, "flags/ports",
          {lkp_flags, lkp_sport, lkp_dport}, {fl, sp, dp});
      chk(lkp_seq == sq && lkp_rver == rv, req, "seq/rver", {lkp_seq, lkp_rver}, {sq, rv});
      chk(lkp_key == exp_key(ks), req, "key", lkp_key, exp_key(ks));
   endtask

   task automatic chk_invalid(input int idx, input string req);
      lkp_idx = IW'(idx);
      #1;
      chk(!lkp_valid, req, $sformatf("entry %0d invalid", idx), lkp_valid, 0);
   endtask

   task automatic quiet(input int cycles, input string req);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         chk(!out_valid, req, "no response", out_valid, 0);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(in_ready && !out_valid && !err_pulse, "R1", "ready/valid/err after reset",
          {in_ready, out_valid, err_pulse}, 3'b100);
      for (int i = 0; i < DEPTH; i++) chk_invalid(i, "R1");
   endtask

   task automatic t_setup_basic;
      // R2 framing, R3 capture; flags 0xB = TCP, valid, IPv6; rver 0x30 = TLS 1.2
      set_fields(CMD_SETUP, 32'h1234_5673, 4'hB, 16'hC001, 16'h01BB, 32'hDEAD_BEEF, 8'h30, 8'h40);
      do_setup(1'b0);
      chk_entry(32'h1234_5673, 4'hB, 16'hC001, 16'h01BB, 32'hDEAD_BEEF, 8'h30, 8'h40, "R3");
   endtask

   task automatic t_setup_stall;
      set_fields(CMD_SETUP, 32'hA000_0005, 4'h6, 16'h1111, 16'h2222, 32'h0000_0010, 8'h31, 8'h90);
      do_setup(1'b1);
      chk_entry(32'hA000_0005, 4'h6, 16'h1111, 16'h2222, 32'h0000_0010, 8'h31, 8'h90, "R3");
   endtask

   task automatic t_alias;
      set_fields(CMD_SETUP, 32'h0000_000B, 4'h4, 16'h3333, 16'h4444, 32'h7777_0000, 8'h30, 8'hE0);
      do_setup(1'b0);
      chk_entry(32'h0000_000B, 4'h4, 16'h3333, 16'h4444, 32'h7777_0000, 8'h30, 8'hE0, "R10");
   endtask

   task automatic t_teardown;
      set_fields(CMD_TEAR, 32'hA000_0005, 4'h0, '0, '0, '0, '0, '0);
      send_msg(TEAR_LEN);
      chk(!err_pulse, "R5", "no error on teardown", err_pulse, 0);
      quiet(4, "R5");
      chk_invalid(5, "R5");
      chk_entry(32'h0000_000B, 4'h4, 16'h3333, 16'h4444, 32'h7777_0000, 8'h30, 8'hE0, "R5");
   endtask

   task automatic t_unknown;
      set_fields(8'h07, 32'h0000_0003, 4'h0, '0, '0, '0, '0, '0);
      send_msg(10);
      chk(err_pulse, "R6", "error pulse", err_pulse, 1);
      @(negedge clk);
      chk(!err_pulse && !out_valid, "R6", "pulse ends, no response", {err_pulse, out_valid}, 0);
      quiet(3, "R6");
      chk_entry(32'h0000_000B, 4'h4, 16'h3333, 16'h4444, 32'h7777_0000, 8'h30, 8'hE0, "R6");
   endtask

   task automatic t_badlen;
      set_fields(CMD_SETUP, 32'h0000_0006, 4'hF, 16'h5555, 16'h6666, 32'h1, 8'h30, 8'h10);
      send_msg(100);
      chk(err_pulse, "R7", "short setup error", err_pulse, 1);
      quiet(4, "R7");
      chk_invalid(6, "R7");
      set_fields(CMD_TEAR, 32'h0000_000B, 4'h0, '0, '0, '0, '0, '0);
      send_msg(TEAR_LEN + 1);
      chk(err_pulse, "R7", "long teardown error", err_pulse, 1);
      quiet(2, "R7");
      chk_entry(32'h0000_000B, 4'h4, 16'h3333, 16'h4444, 32'h7777_0000, 8'h30, 8'hE0, "R7");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_setup_basic();
      t_setup_stall();
      t_alias();
      t_teardown();
      t_unknown();
      t_badlen();
      chk(in_ready, "R8", "ready restored when idle", in_ready, 1);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1ms;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule